// File: doc/BRIEF.md
# Processor clock source controller

The block picks the CPU clock-enable from one of two tick sources sampled in a single system clock domain: a fast main oscillator, divided by a programmable ratio, or a slow subsystem oscillator, passed through. A small control register selects the source, sets the main-clock ratio and can ask for the main oscillator to be stopped. The register reads back a status bit that shows which source the CPU is actually using.

A source change waits for the period of the current clock-enable to finish, so no pulse is ever cut short. The request to stop the main oscillator is interlocked with that status. The oscillator enable drops only once the CPU is running from the subsystem ticks, in whichever order the two request bits were written. A return to the main source is refused while the stop request is held. After the request is released, it waits for a fixed count of main ticks so the oscillator can settle.

Top module: `pclk_src_ctrl`

## Requirements
- R1: After reset, rd_data_o reads 0x00, main_osc_en_o is 1, and the CPU runs from the main ticks at the slowest ratio (divide by 16).
- R2: Register layout: bits 2:0 hold the ratio code, bit 4 holds the source request (1 = subsystem), bit 7 holds the stop request, and bit 5 is the read-only status (1 = running from subsystem). Bits 6 and 3 read 0. Writes to bit 5 are ignored.
- R3: On the main source, cpu_clk_en_o gives one pulse per N main ticks. Ratio codes 0, 1, 2, 3 and 4 select N = 16, 8, 4, 2 and 1. Codes 5 to 7 select N = 16.
- R4: With the source request at 1, status goes from 0 to 1 only on the clock edge at which a divided main pulse occurs.
- R5: While status is 1, cpu_clk_en_o equals sub_tick_i.
- R6: main_osc_en_o is low exactly when both the stop request and the status are 1. If status is already 1, the enable drops at the edge that writes the stop request.
- R7: If the stop request is written while status is 0, the enable stays high. It drops at the edge at which status later becomes 1.
- R8: While the stop request is 1, status stays 1 even if the source request is 0. After the stop request clears, status returns to 0 only at a sub tick edge, and only once SETTLE (default 4) main ticks have been seen with the oscillator enabled.
- R9: While main_osc_en_o is low, main ticks are ignored: they produce no pulses and make no settle progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| main_tick_i | input | 1 | Main oscillator tick |
| sub_tick_i | input | 1 | Subsystem oscillator tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read-back with status |
| main_osc_en_o | output | 1 | Main oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock-enable pulse |

## Verification
A register write of the combined source and stop request can land in the same cycle as a main divided pulse. That pulse is the boundary at which a source change would occur. The bench provokes this by asserting the write strobe and a main tick together at divide-by-1. Because the request is not yet registered at that edge, status and the oscillator enable must stay unchanged. Both must then change together at the following main tick edge.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int unsigned DivLog2Max = 4;
  localparam int unsigned SelW       = 3;
  localparam int unsigned RegW       = 8;
  localparam int unsigned DivLsb     = 0;
  localparam int unsigned SrcBit     = 4;
  localparam int unsigned StatBit    = 5;
  localparam int unsigned StopBit    = 7;

  // code -> log2 of ratio; reserved codes fall back to slowest
  function automatic int unsigned div_log2(input logic [SelW-1:0] sel);
    if (int'(sel) > int'(DivLog2Max)) return DivLog2Max;
    return DivLog2Max - int'(sel);
  endfunction
endpackage

// File: rtl/pclk_ctrl_reg.sv
module pclk_ctrl_reg
  import pclk_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [RegW-1:0]     wr_data_i,
  input  logic                status_i,
  output logic [SelW-1:0]     div_sel_o,
  output logic                src_req_o,
  output logic                stop_req_o,
  output logic [RegW-1:0]     rd_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_sel_o  <= '0;
      src_req_o  <= 1'b0;
      stop_req_o <= 1'b0;
    end else if (wr_en_i) begin
      div_sel_o  <= wr_data_i[DivLsb +: SelW];
      src_req_o  <= wr_data_i[SrcBit];
      stop_req_o <= wr_data_i[StopBit];
    end
  end

  always_comb begin
    rd_data_o                  = '0;
    rd_data_o[DivLsb +: SelW]  = div_sel_o;
    rd_data_o[SrcBit]          = src_req_o;
    rd_data_o[StatBit]         = status_i;
    rd_data_o[StopBit]         = stop_req_o;
  end
endmodule

// File: rtl/pclk_div.sv
module pclk_div
  import pclk_pkg::*;
#(
  parameter int unsigned LOG2_MAX = DivLog2Max,
  parameter int unsigned SEL_W    = SelW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pulse_o
);
  localparam int unsigned CntW = (LOG2_MAX < 1) ? 1 : LOG2_MAX;

  logic [CntW-1:0] cnt_q;
  logic [CntW-1:0] limit;

  always_comb begin
    limit   = CntW'((32'd1 << div_log2(sel_i)) - 32'd1);
    pulse_o = tick_i && (cnt_q >= limit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= pulse_o ? '0 : cnt_q + 1'b1;
  end

  // R3
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> cnt_q == '0);
  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !clr_i |=> $stable(cnt_q));
endmodule

// File: rtl/pclk_seq.sv
module pclk_seq #(
  parameter int unsigned SETTLE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_req_i,
  input  logic stop_req_i,
  input  logic osc_en_i,
  input  logic main_tick_i,
  input  logic main_pulse_i,
  input  logic sub_tick_i,
  output logic status_o,
  output logic div_clr_o
);
  localparam int unsigned SetW = $clog2(SETTLE + 1);

  logic [SetW-1:0] settle_q;
  logic            ready;
  logic            go_sub, go_main;

  assign ready     = (settle_q == SetW'(SETTLE));
  assign go_sub    = !status_o && src_req_i && main_pulse_i;
  assign go_main   = status_o && !src_req_i && !stop_req_i && ready && sub_tick_i;
  assign div_clr_o = go_main;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               settle_q <= SetW'(SETTLE);
    else if (!osc_en_i)                        settle_q <= '0;
    else if (main_tick_i && !ready)            settle_q <= settle_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      status_o <= 1'b0;
    else if (go_sub)  status_o <= 1'b1;
    else if (go_main) status_o <= 1'b0;
  end

  // R4
  sub_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o) |-> $past(main_pulse_i) && $past(src_req_i));
  // R8
  hold_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o && stop_req_i |=> status_o);
  // R8
  main_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o) |-> $past(sub_tick_i) && $past(ready));
endmodule

// File: rtl/pclk_src_ctrl.sv
module pclk_src_ctrl
  import pclk_pkg::*;
#(
  parameter int unsigned SETTLE = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            main_tick_i,
  input  logic            sub_tick_i,
  input  logic            wr_en_i,
  input  logic [RegW-1:0] wr_data_i,
  output logic [RegW-1:0] rd_data_o,
  output logic            main_osc_en_o,
  output logic            cpu_clk_en_o
);
  logic [SelW-1:0] div_sel;
  logic            src_req, stop_req, status;
  logic            main_tick_g, main_pulse, div_clr;

  pclk_ctrl_reg i_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .status_i  (status),
    .div_sel_o (div_sel),
    .src_req_o (src_req),
    .stop_req_o(stop_req),
    .rd_data_o
  );

  // oscillator only stops once CPU is on subsystem ticks
  assign main_osc_en_o = !(stop_req && status);
  assign main_tick_g   = main_tick_i && main_osc_en_o;

  pclk_div #(.LOG2_MAX(DivLog2Max), .SEL_W(SelW)) i_div (
    .clk_i, .rst_ni,
    .tick_i (main_tick_g),
    .clr_i  (div_clr),
    .sel_i  (div_sel),
    .pulse_o(main_pulse)
  );

  pclk_seq #(.SETTLE(SETTLE)) i_seq (
    .clk_i, .rst_ni,
    .src_req_i   (src_req),
    .stop_req_i  (stop_req),
    .osc_en_i    (main_osc_en_o),
    .main_tick_i (main_tick_g),
    .main_pulse_i(main_pulse),
    .sub_tick_i,
    .status_o    (status),
    .div_clr_o   (div_clr)
  );

  assign cpu_clk_en_o = status ? sub_tick_i : main_pulse;

  // R6
  osc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_osc_en_o |-> rd_data_o[StatBit] && rd_data_o[StopBit]);
  // R9
  stopped_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_osc_en_o |-> cpu_clk_en_o == sub_tick_i);
endmodule

// File: tb/test_pclk_src_ctrl.sv
module test_pclk_src_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_tick = 1'b0, sub_tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       osc_en, cpu_en;
  int         total = 0, bad = 0;

  always #2 clk = ~clk;

  pclk_src_ctrl i_pclk_src_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .main_tick_i(main_tick), .sub_tick_i(sub_tick),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .main_osc_en_o(osc_en), .cpu_clk_en_o(cpu_en)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; main_tick = 0; sub_tick = 0; wr_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic mtick(input int exp_pulse, input string req);
    @(negedge clk);
    main_tick = 1'b1;
    #1 if (exp_pulse >= 0) chk(req, "cpu_en at main tick", int'(cpu_en), exp_pulse);
    @(posedge clk); #1;
    main_tick = 1'b0;
  endtask

  task automatic stick(input string req);
    @(negedge clk);
    sub_tick = 1'b1;
    #1 if (rd_data[5]) chk(req, "cpu_en follows sub tick", int'(cpu_en), 1);
    @(posedge clk); #1;
    sub_tick = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1", "rd_data", int'(rd_data), 0);
    chk("R1", "osc_en", int'(osc_en), 1);
    chk("R1", "cpu_en idle", int'(cpu_en), 0);
  endtask

  task automatic t_layout();
    do_reset();
    wr(8'h68);
    chk("R2", "reserved and status bits", int'(rd_data), 0);
    wr(8'h97);
    chk("R2", "fields read back", int'(rd_data), 8'h97);
  endtask

  task automatic t_ratio();
    do_reset();
    for (int v = 0; v < 8; v++) begin
      int n;
      int cnt;
      n = (v <= 4) ? (16 >> v) : 16;
      wr(8'(v));
      @(negedge clk); main_tick = 1'b1;
      repeat (16) @(negedge clk);
      cnt = 0;
      for (int k = 0; k < 32; k++) begin
        @(negedge clk); #1;
        if (cpu_en) cnt++;
      end
      chk("R3", $sformatf("pulses in 32 ticks code %0d", v), cnt, 32 / n);
      main_tick = 1'b0;
    end
  endtask

  task automatic t_src_first();
    do_reset();
    wr(8'h14);
    repeat (3) @(negedge clk);
    chk("R4", "no switch without boundary", int'(rd_data[5]), 0);
    mtick(1, "R3");
    chk("R4", "status at boundary", int'(rd_data[5]), 1);
    chk("R6", "osc on before stop", int'(osc_en), 1);
    stick("R5");
    wr(8'h94);
    chk("R6", "osc off at stop write", int'(osc_en), 0);
    chk("R2", "readback stopped", int'(rd_data), 8'hB4);
  endtask

  task automatic t_stop_first();
    do_reset();
    wr(8'h84);
    chk("R7", "osc on, still main", int'(osc_en), 1);
    mtick(1, "R7");
    chk("R7", "status stays 0", int'(rd_data[5]), 0);
    chk("R7", "osc still on", int'(osc_en), 1);
    wr(8'h94);
    chk("R7", "osc on after src write", int'(osc_en), 1);
    mtick(1, "R7");
    chk("R7", "status at boundary", int'(rd_data[5]), 1);
    chk("R7", "osc off at boundary", int'(osc_en), 0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr(8'h04);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h94; main_tick = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; main_tick = 1'b0;
    chk("R4", "write and pulse same edge: status", int'(rd_data[5]), 0);
    chk("R7", "write and pulse same edge: osc", int'(osc_en), 1);
    mtick(1, "R3");
    chk("R7", "osc off next boundary", int'(osc_en), 0);
  endtask

  task automatic t_return();
    // continues from stopped state on subsystem ticks
    wr(8'h84);
    stick("R5"); stick("R5");
    chk("R8", "no return while stopped", int'(rd_data[5]), 1);
    for (int k = 0; k < 10; k++) mtick(0, "R9");
    wr(8'h04);
    chk("R8", "osc back on", int'(osc_en), 1);
    repeat (3) mtick(-1, "R8");
    stick("R8");
    chk("R8", "settle not done", int'(rd_data[5]), 1);
    mtick(-1, "R8");
    chk("R8", "no return without sub tick", int'(rd_data[5]), 1);
    stick("R8");
    chk("R8", "returned to main", int'(rd_data[5]), 0);
    mtick(1, "R3");
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_layout();
    t_ratio();
    t_src_first();
    t_stop_first();
    t_same_cycle();
    t_return();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule